// File: doc/BRIEF.md
# Replayable DMA Peer Port

This block is the peer-side access controller for one direction of a FIFO pair. A peripheral moves 18-bit words through it under a request/acknowledge DMA handshake, while the control side of the chip fills or drains the same storage through a simple pointer interface. The storage array is outside the block. The block supplies the peer-side address, the write strobe and a straight data path, and it supplies the near-side address and a go/ready pair. The `mode_rd` input fixes the direction at reset. When it is 1, the peer reads and the near side writes. When it is 0, the peer writes and the near side reads.

The peer can pin the start of a data block and later move its pointer back to that point. In read mode this replays stored words (reread). In write mode it overwrites the same region (rewrite). While a block is pinned, the near side is kept from disturbing it. In read mode, free space for the near writer is counted from the pin rather than from the live read pointer. In write mode, the near reader sees only the words committed before the pin. Six general-purpose pins are driven from two small configuration registers, one for direction and one for value.

Two state machines carry the control. The handshake machine has two states. `HS_IDLE` drives request low and moves to `HS_REQ` when a word will be movable next cycle. `HS_REQ` drives request high and returns to `HS_IDLE` once nothing remains to move. The block machine also has two states. `BLK_FREE` moves to `BLK_HELD` on a mark command. `BLK_HELD` takes a fresh pin on a repeat mark, and it returns to `BLK_FREE` on a release command.

Top module: `rrdma_port`

## Requirements
- R1: While `rst_n` is low, `dma_req` is 0, both addresses are 0, `gpio_oe` and `gpio_out` are 0 and no block is pinned. In write mode, `dma_req` rises on the first clock edge after reset is released.
- R2: In read mode, `dma_req` is high whenever at least one stored word is unread. Each cycle with `dma_req` and `dma_ack` both high consumes the word at `peer_addr` (shown on `peer_rdata`), and words come out in the order they were stored.
- R3: `dma_req` is low in the cycle after the transfer that leaves nothing to move: the last word in read mode, the last free slot in write mode. No transfer ever occurs from an empty store or into a full one.
- R4: In write mode, `dma_req` is high whenever a slot is free. Each transfer cycle raises `mem_we` and writes `peer_wdata` to `peer_addr`, and `mem_we` is low in every other cycle.
- R5: `near_ok` reports free space in read mode and committed data in write mode. A `near_go` pulse while `near_ok` is low leaves `near_addr` unchanged. Otherwise it advances `near_addr` by one, modulo DEPTH.
- R6: `cmd_mark` latches the current peer pointer as the pin and enters the held state. In read mode, while the block is held, near-side space is counted from the pin, so words after the pin are never overwritten.
- R7: In read mode, `cmd_replay` while held reloads the read pointer from the pin, and the same words are delivered again. Replay takes priority over a transfer in the same cycle.
- R8: In write mode, `cmd_replay` while held reloads the write pointer from the pin. While the block is held, the near side sees only words written before the pin, so `near_ok` stays low if none exist.
- R9: `cmd_release` clears the held state and wins over `cmd_mark` in the same cycle. `cmd_replay` without a held block has no effect on `peer_addr`.
- R10: A configuration write with `cfg_sel`=0 sets the direction register, where 1 means drive the pin. A write with `cfg_sel`=1 sets the value register. `gpio_oe` shows the direction register and `gpio_out` shows the value register.
- R11: `cfg_rdata` returns the direction register when `cfg_sel`=0. When `cfg_sel`=1, it returns the stored value for pins set as outputs and the live `gpio_in` level for pins set as inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transfer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_rd | input | 1 | 1: peer reads, 0: peer writes; static after reset |
| dma_req | output | 1 | Peer may move a word |
| dma_ack | input | 1 | Peer moves a word this cycle |
| peer_wdata | input | 18 | Word from peer (write mode) |
| peer_rdata | output | 18 | Word to peer (read mode) |
| near_go | input | 1 | Near side performs one word operation |
| near_ok | output | 1 | Near side may operate |
| near_addr | output | 4 | Storage address for near side |
| peer_addr | output | 4 | Storage address for peer side |
| mem_we | output | 1 | Peer-side storage write strobe |
| mem_wdata | output | 18 | Peer-side storage write data |
| mem_rdata | input | 18 | Storage data at `peer_addr` |
| cmd_mark | input | 1 | Pin the block start |
| cmd_replay | input | 1 | Return peer pointer to pin |
| cmd_release | input | 1 | Drop the pin |
| cfg_wr | input | 1 | Configuration register write |
| cfg_sel | input | 1 | 0: direction register, 1: value register |
| cfg_wdata | input | 6 | Configuration write data |
| cfg_rdata | output | 6 | Configuration read data |
| gpio_in | input | 6 | Live pin levels |
| gpio_out | output | 6 | Pin drive values |
| gpio_oe | output | 6 | Pin drive enables |

## Verification
The assertions assume that `mode_rd` changes only while reset is low, and that the storage returns `mem_rdata` for `peer_addr` in the same cycle. They make no assumption about the order of commands or about `dma_ack` being high while request is low. The stimulus holds `mode_rd` fixed between resets and models the storage as a combinational-read array. Random mixes of acknowledge, near-side operations, marks, replays and releases are checked against a pointer model kept as unbounded integers, so the wrap arithmetic is never copied. Directed runs fill the store completely, drain it, and exercise replay both with and without a held block.

// File: rtl/rrdma_pkg.sv
package rrdma_pkg;
    typedef enum logic {HS_IDLE, HS_REQ} hs_state_e;
    typedef enum logic {BLK_FREE, BLK_HELD} blk_state_e;
endpackage

// File: rtl/rrdma_hs.sv
module rrdma_hs
    import rrdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic avail_nxt,
    input  logic dma_ack,
    output logic dma_req,
    output logic peer_xfer
);
    hs_state_e state_q, state_n;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= HS_IDLE;
        else        state_q <= state_n;
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            HS_IDLE: if (avail_nxt)  state_n = HS_REQ;
            HS_REQ:  if (!avail_nxt) state_n = HS_IDLE;
        endcase
    end

    always_comb begin
        dma_req   = (state_q == HS_REQ);
        peer_xfer = dma_req & dma_ack;
    end

    // R3: request withdrawn right after the final movable word
    assert_req_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (peer_xfer && !avail_nxt) |=> !dma_req);
endmodule

// File: rtl/rrdma_ptr.sv
module rrdma_ptr
    import rrdma_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_rd,
    input  logic          peer_xfer,
    input  logic          near_go,
    input  logic          cmd_mark,
    input  logic          cmd_replay,
    input  logic          cmd_release,
    output logic          near_ok,
    output logic          avail_nxt,
    output logic [AW-1:0] near_addr,
    output logic [AW-1:0] peer_addr
);
    localparam logic [PW-1:0] FULL = PW'(DEPTH);
    localparam logic [PW-1:0] ONE  = PW'(1);

    logic [PW-1:0] rd_q, wr_q, mk_q, rd_n, wr_n, mk_n;
    logic [PW-1:0] peer_ptr, near_ptr, base;
    blk_state_e    blk_q, blk_n;
    logic          held, near_do;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            mk_q  <= '0;
            blk_q <= BLK_FREE;
        end else begin
            rd_q  <= rd_n;
            wr_q  <= wr_n;
            mk_q  <= mk_n;
            blk_q <= blk_n;
        end
    end

    always_comb begin
        held     = (blk_q == BLK_HELD);
        peer_ptr = mode_rd ? rd_q : wr_q;
        near_ptr = mode_rd ? wr_q : rd_q;
        base     = held ? mk_q : peer_ptr;
        near_ok  = mode_rd ? (PW'(wr_q - base) != FULL) : (base != rd_q);
        near_do  = near_go & near_ok;
        near_addr = near_ptr[AW-1:0];
        peer_addr = peer_ptr[AW-1:0];
    end

    always_comb begin
        rd_n  = rd_q;
        wr_n  = wr_q;
        mk_n  = mk_q;
        blk_n = blk_q;
        if (mode_rd) begin
            if (cmd_replay && held) rd_n = mk_q;
            else if (peer_xfer)     rd_n = rd_q + ONE;
            if (near_do)            wr_n = wr_q + ONE;
        end else begin
            if (cmd_replay && held) wr_n = mk_q;
            else if (peer_xfer)     wr_n = wr_q + ONE;
            if (near_do)            rd_n = rd_q + ONE;
        end
        unique case (blk_q)
            BLK_FREE: if (cmd_mark && !cmd_release) begin
                blk_n = BLK_HELD;
                mk_n  = peer_ptr;
            end
            BLK_HELD: begin
                if (cmd_release)   blk_n = BLK_FREE;
                else if (cmd_mark) mk_n  = peer_ptr;
            end
        endcase
        avail_nxt = mode_rd ? (wr_n != rd_n) : (PW'(wr_n - rd_n) != FULL);
    end

    assert_no_underrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd && peer_xfer) |-> (wr_q != rd_q));
    assert_no_overrun_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_rd && peer_xfer) |-> (PW'(wr_q - rd_q) != FULL));
    assert_block_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd && held) |-> (PW'(wr_q - mk_q) <= FULL));
    assert_reread_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd && held && cmd_replay) |=> (rd_q == $past(mk_q)));
    assert_rewrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_rd && held && cmd_replay) |=> (wr_q == $past(mk_q)));
    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_release |=> (blk_q == BLK_FREE));
endmodule

// File: rtl/rrdma_pio.sv
module rrdma_pio #(
    parameter int NPIO = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic            cfg_sel,
    input  logic [NPIO-1:0] cfg_wdata,
    input  logic [NPIO-1:0] gpio_in,
    output logic [NPIO-1:0] cfg_rdata,
    output logic [NPIO-1:0] gpio_out,
    output logic [NPIO-1:0] gpio_oe
);
    logic [NPIO-1:0] dir_q, val_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            val_q <= '0;
        end else if (cfg_wr) begin
            if (cfg_sel) val_q <= cfg_wdata;
            else         dir_q <= cfg_wdata;
        end
    end

    always_comb begin
        gpio_oe   = dir_q;
        gpio_out  = val_q;
        cfg_rdata = cfg_sel ? ((val_q & dir_q) | (gpio_in & ~dir_q)) : dir_q;
    end

    assert_dir_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_sel) |=> (gpio_oe == $past(cfg_wdata)));
    assert_val_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_sel) |=> (gpio_out == $past(cfg_wdata)));
endmodule

// File: rtl/rrdma_port.sv
module rrdma_port #(
    parameter int DEPTH = 16,
    parameter int W     = 18,
    parameter int NPIO  = 6,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_rd,
    output logic            dma_req,
    input  logic            dma_ack,
    input  logic [W-1:0]    peer_wdata,
    output logic [W-1:0]    peer_rdata,
    input  logic            near_go,
    output logic            near_ok,
    output logic [AW-1:0]   near_addr,
    output logic [AW-1:0]   peer_addr,
    output logic            mem_we,
    output logic [W-1:0]    mem_wdata,
    input  logic [W-1:0]    mem_rdata,
    input  logic            cmd_mark,
    input  logic            cmd_replay,
    input  logic            cmd_release,
    input  logic            cfg_wr,
    input  logic            cfg_sel,
    input  logic [NPIO-1:0] cfg_wdata,
    output logic [NPIO-1:0] cfg_rdata,
    input  logic [NPIO-1:0] gpio_in,
    output logic [NPIO-1:0] gpio_out,
    output logic [NPIO-1:0] gpio_oe
);
    logic avail_nxt, peer_xfer;

    rrdma_hs u_hs (
        .clk       (clk),
        .rst_n     (rst_n),
        .avail_nxt (avail_nxt),
        .dma_ack   (dma_ack),
        .dma_req   (dma_req),
        .peer_xfer (peer_xfer)
    );

    rrdma_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_rd     (mode_rd),
        .peer_xfer   (peer_xfer),
        .near_go     (near_go),
        .cmd_mark    (cmd_mark),
        .cmd_replay  (cmd_replay),
        .cmd_release (cmd_release),
        .near_ok     (near_ok),
        .avail_nxt   (avail_nxt),
        .near_addr   (near_addr),
        .peer_addr   (peer_addr)
    );

    rrdma_pio #(.NPIO(NPIO)) u_pio (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .gpio_in   (gpio_in),
        .cfg_rdata (cfg_rdata),
        .gpio_out  (gpio_out),
        .gpio_oe   (gpio_oe)
    );

    always_comb begin
        mem_we     = peer_xfer & ~mode_rd;
        mem_wdata  = peer_wdata;
        peer_rdata = mem_rdata;
    end

    // R4: storage write strobe only with a granted write-mode transfer
    assert_we_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (dma_req && dma_ack && !mode_rd));
endmodule

// File: tb/tb_rrdma_port.sv
`timescale 1ns/1ps
module tb_rrdma_port;
    localparam int D = 16;
    localparam int W = 18;
    localparam int NP = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, mode_rd, dma_req, dma_ack, near_go, near_ok, mem_we;
    logic [W-1:0] peer_wdata, peer_rdata, mem_wdata, mem_rdata, near_data;
    logic [3:0] near_addr, peer_addr;
    logic cmd_mark, cmd_replay, cmd_release, cfg_wr, cfg_sel;
    logic [NP-1:0] cfg_wdata, cfg_rdata, gpio_in, gpio_out, gpio_oe;

    rrdma_port dut (.*);

    logic [W-1:0] mem [D];
    assign mem_rdata = mem[peer_addr];
    always @(posedge clk) begin
        if (mode_rd && near_go && near_ok) mem[near_addr] <= near_data;
        if (mem_we) mem[peer_addr] <= mem_wdata;
    end

    int checks = 0, errors = 0;
    int m_rd, m_wr, m_mk;
    bit m_held, fresh, done = 0;
    logic [W-1:0] mdl [D];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit f_peer_avail();
        return mode_rd ? (m_wr - m_rd) > 0 : (m_wr - m_rd) < D;
    endfunction
    function automatic int f_peer_ptr();
        return mode_rd ? m_rd : m_wr;
    endfunction
    function automatic bit f_near_ok();
        int b = m_held ? m_mk : f_peer_ptr();
        return mode_rd ? (m_wr - b) < D : (b - m_rd) > 0;
    endfunction

    task automatic do_reset(bit md);
        rst_n = 0; mode_rd = md; dma_ack = 0; near_go = 0; near_data = '0;
        peer_wdata = '0; cmd_mark = 0; cmd_replay = 0; cmd_release = 0;
        cfg_wr = 0; cfg_sel = 0; cfg_wdata = '0; gpio_in = '0;
        repeat (3) @(negedge clk);
        m_rd = 0; m_wr = 0; m_mk = 0; m_held = 0;
        chk("R1 req", dma_req, 0);
        chk("R1 peer_addr", peer_addr, 0);
        chk("R1 near_addr", near_addr, 0);
        chk("R1 gpio_oe", gpio_oe, 0);
        chk("R1 gpio_out", gpio_out, 0);
        rst_n = 1; fresh = 1;
    endtask

    task automatic step(bit ack, bit go, bit mk, bit rp, bit rl, logic [W-1:0] d);
        bit er, xf, nd;
        int pp;
        dma_ack = ack; near_go = go; near_data = d; peer_wdata = d;
        cmd_mark = mk; cmd_replay = rp; cmd_release = rl;
        #1;
        er = f_peer_avail() && !fresh;
        chk(mode_rd ? "R2/R3 req" : "R1/R3/R4 req", dma_req, er);
        chk(mode_rd ? "R5/R6 near_ok" : "R5/R8 near_ok", near_ok, f_near_ok());
        chk("R7/R8/R9 peer_addr", peer_addr, f_peer_ptr() % D);
        chk("R5 near_addr", near_addr, (mode_rd ? m_wr : m_rd) % D);
        xf = er && ack;
        nd = go && f_near_ok();
        chk("R4 mem_we", mem_we, xf && !mode_rd);
        if (mode_rd && xf) chk("R2/R7 data", peer_rdata, mdl[m_rd % D]);
        if (!mode_rd && nd) chk("R4/R8 data", mem[near_addr], mdl[m_rd % D]);
        pp = f_peer_ptr();
        if (mode_rd) begin
            if (rp && m_held) m_rd = m_mk;
            else if (xf) m_rd++;
            if (nd) begin mdl[m_wr % D] = d; m_wr++; end
        end else begin
            if (rp && m_held) m_wr = m_mk;
            else if (xf) begin mdl[m_wr % D] = d; m_wr++; end
            if (nd) m_rd++;
        end
        if (rl) m_held = 0;
        else if (mk) begin m_held = 1; m_mk = pp; end
        fresh = 0;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic rnd_run(int n);
        for (int i = 0; i < n; i++) begin
            int r = $urandom % 100;
            step(($urandom % 10) < 7, $urandom % 2, r < 3, r >= 3 && r < 6,
                 r >= 6 && r < 9, W'($urandom));
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] dv, vv;
        void'($urandom(32'h5eed));
        for (int i = 0; i < D; i++) begin mem[i] = '0; mdl[i] = '0; end
        do_reset(1);
        // R11/R10 directed and random pin register checks
        @(negedge clk); cfg_wr = 1; cfg_sel = 0; cfg_wdata = 6'b101100;
        @(negedge clk); cfg_sel = 1; cfg_wdata = 6'b111010;
        @(negedge clk); cfg_wr = 0;
        chk("R10 gpio_oe", gpio_oe, 6'b101100);
        chk("R10 gpio_out", gpio_out, 6'b111010);
        gpio_in = 6'b010101; cfg_sel = 1; #1;
        chk("R11 value readback", cfg_rdata, 6'b111001);
        cfg_sel = 0; #1;
        chk("R11 dir readback", cfg_rdata, 6'b101100);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            dv = NP'($urandom); vv = NP'($urandom);
            cfg_wr = 1; cfg_sel = 0; cfg_wdata = dv;
            @(negedge clk); cfg_sel = 1; cfg_wdata = vv;
            @(negedge clk); cfg_wr = 0; gpio_in = NP'($urandom); #1;
            chk("R10 random oe", gpio_oe, dv);
            chk("R11 random readback", cfg_rdata, (vv & dv) | (gpio_in & ~dv));
        end
        // read mode directed
        do_reset(1);
        step(0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, W'(18'h100 + i));
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0);                         // R3: req low after last word
        for (int i = 0; i < D + 2; i++) step(0, 1, 0, 0, 0, W'(18'h200 + i));
        step(0, 0, 0, 1, 0, 0);                         // R9: replay without pin ignored
        step(0, 0, 1, 0, 0, 0);                         // R6 mark
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0);
        step(0, 1, 0, 0, 0, 18'h3ffff);                 // R6: no space while held
        step(1, 0, 0, 1, 0, 0);                         // R7 replay wins over ack
        for (int i = 0; i < 4; i++) step(1, 0, 0, 0, 0, 0);
        step(0, 0, 1, 0, 1, 0);                         // R9 release beats mark
        step(0, 1, 0, 0, 0, 18'h2aaaa);
        rnd_run(3000);
        // write mode directed
        do_reset(0);
        step(0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, W'(18'h400 + i));
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0);                         // R8 mark
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, W'(18'h500 + i));
        step(0, 1, 0, 0, 0, 0);                         // R8: nothing committed
        step(0, 0, 0, 1, 0, 0);                         // R8 rewrite
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, W'(18'h600 + i));
        step(0, 0, 0, 0, 1, 0);                         // R9 release commits
        for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, 0);
        for (int i = 0; i < D + 1; i++) step(1, 0, 0, 0, 0, W'(18'h700 + i));
        step(1, 0, 0, 0, 0, 0);                         // R3: full, req low
        rnd_run(3000);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule